// File: doc/BRIEF.md
# Oversampled Serial Receiver with Break Detection

This block receives asynchronous serial characters on a single line. The line is sampled on a tick that runs at sixteen times the bit rate. Each character has one low start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. The block sends each received byte out on a data bus, together with a valid strobe that lasts one clock cycle. It also keeps three sticky status flags: framing error, parity error and break.

When a character arrives with every data bit low, the parity bit (if used) low and the stop bit low, the line is taken to be in a break. Such a frame raises only the break flag. It delivers no byte and does not touch the framing-error flag. The receiver then waits for the line to go idle again. It starts no new frame until the line has been high for two consecutive oversample ticks, and at that point it raises the break flag a second time to mark the end of the break. Software reads the flags and clears all of them with a one-cycle reset-status strobe.

The parity enable and the odd/even select are static configuration inputs. The line input passes through a two-stage synchronizer before the frame state machine uses it.

Top module: `uart_brk_rx`

States of the frame machine, `rx_state_t`:

| State | Role |
|---|---|
| ST_IDLE | Waits for a tick with the line low. |
| ST_START | Counts 8 ticks, then confirms the start bit. |
| ST_DATA | Samples each data bit at tick 16 of its bit. |
| ST_PARITY | Samples the parity bit. |
| ST_STOP | Samples the stop bit and classifies the frame. |
| ST_BRK_WAIT | Waits for the end of a break. |

Transitions of the frame machine:

| From | To | Condition |
|---|---|---|
| ST_IDLE | ST_START | tick with the line low |
| ST_START | ST_IDLE | line high at the start sample (glitch) |
| ST_START | ST_DATA | line low at the start sample |
| ST_DATA | ST_PARITY | last data bit sampled and parity enabled |
| ST_DATA | ST_STOP | last data bit sampled and parity disabled |
| ST_PARITY | ST_STOP | parity bit sampled |
| ST_STOP | ST_IDLE | normal frame |
| ST_STOP | ST_BRK_WAIT | break frame |
| ST_BRK_WAIT | ST_IDLE | second consecutive high tick |

## Requirements
- R1: After reset, `rx_valid`, `rx_data`, `frame_err`, `parity_err` and `brk_flag` are all 0.
- R2: A frame is received with its data bits least significant bit first. Each bit is sampled 16 ticks after the previous sample. The byte appears on `rx_data` together with a `rx_valid` pulse that lasts exactly one clock cycle. `rx_data` holds the byte until the next valid frame.
- R3: A start is detected on a tick that sees the line low. It is confirmed 8 ticks later. If the line is high at that point, the event is ignored: no byte is delivered and no flag changes.
- R4: When `par_en`=1, a parity bit follows the data bits. With `par_odd`=0 the correct parity bit is the XOR of the data bits (even parity). With `par_odd`=1 it is the inverse of that XOR (odd parity). A mismatch sets `parity_err` in the same cycle as the `rx_valid` pulse. When `par_en`=0, no parity bit is expected and `parity_err` is never set.
- R5: A stop bit sampled low on a frame that is not a break sets `frame_err` in the same cycle as `rx_valid`. The byte is still delivered.
- R6: A frame is a break when all data bits, the parity bit (if enabled) and the stop bit are low. A break frame sets `brk_flag`, produces no `rx_valid` pulse, and sets neither `frame_err` nor `parity_err`.
- R7: After a break frame the receiver starts no new frame until the line has been high on two consecutive ticks. A single high tick does not end the break. End of break sets `brk_flag` again, and a normal frame can follow.
- R8: A `rst_status` pulse clears `frame_err`, `parity_err` and `brk_flag` on the next clock edge. If a set event arrives in the same cycle, the clear wins.
- R9: Each status flag stays set until `rst_status` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversample tick, 16 per bit period, one clock cycle wide |
| rxd | input | 1 | Serial line, idle high |
| par_en | input | 1 | 1 = a parity bit follows the data bits |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rst_status | input | 1 | Clears all status flags |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a new byte |
| frame_err | output | 1 | Sticky framing-error flag |
| parity_err | output | 1 | Sticky parity-error flag |
| brk_flag | output | 1 | Sticky flag for break start and break end |

## Verification
The bench sends frames through the following corner cases:
- **All-zero break frame, with and without parity.** A design that checks the stop bit before the break condition would raise `frame_err` on a break, and one that ignores parity would call a frame with a high parity bit a break.
- **Break held low long after the frame, with a one-tick high glitch.** A receiver that restarts from idle would deliver bogus bytes during the break. One that ends the break on the first high tick would set the flag early.
- **Short start glitch.** This catches a receiver that commits to a frame without confirming the start bit.
- **Even/odd parity mismatches, a zero stop bit, and clears that land while flags are set.** These expose inverted parity sense, lost bytes on framing errors and non-sticky flags.

Random frames with random parity settings, random parity faults and random stop faults are then checked against a bench model.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_BRK_WAIT
    } rx_state_t;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
        logic       ferr;
        logic       perr;
        logic       brk;
    } rx_evt_t;

endpackage

// File: rtl/uart_brk_sync.sv
module uart_brk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b1;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_brk_fsm.sv
module uart_brk_fsm
    import uart_brk_pkg::*;
#(
    parameter int DATA_BITS     = 8,
    parameter int OVS           = 16,
    parameter int BRK_END_TICKS = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick,
    input  logic    rxd_s,
    input  logic    par_en,
    input  logic    par_odd,
    output rx_evt_t evt
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_BITS + 1);
    localparam int HI_W  = $clog2(BRK_END_TICKS + 1);
    localparam logic [CNT_W-1:0] START_LAST = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] BIT_LAST   = CNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0] IDX_LAST   = IDX_W'(DATA_BITS - 1);
    localparam logic [HI_W-1:0]  HI_LAST    = HI_W'(BRK_END_TICKS - 1);

    rx_state_t            state_q, state_d;
    logic [CNT_W-1:0]     cnt_q;
    logic [IDX_W-1:0]     idx_q;
    logic [DATA_BITS-1:0] shreg_q;
    logic                 par_bit_q;
    logic [HI_W-1:0]      hi_q;

    logic sample_pt;
    logic is_brk;
    logic par_bad;
    logic brk_over;

    // A sample point is the last tick of the current counting window.
    always_comb begin
        if (state_q == ST_START) sample_pt = tick && (cnt_q == START_LAST);
        else                     sample_pt = tick && (cnt_q == BIT_LAST);
    end

    assign is_brk   = (shreg_q == '0) && (!par_en || !par_bit_q) && !rxd_s;
    assign par_bad  = par_en && (par_bit_q != ((^shreg_q) ^ par_odd));
    assign brk_over = tick && rxd_s && (hi_q == HI_LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tick && !rxd_s) state_d = ST_START;
            end
            ST_START: begin
                if (sample_pt) state_d = rxd_s ? ST_IDLE : ST_DATA;
            end
            ST_DATA: begin
                if (sample_pt && (idx_q == IDX_LAST))
                    state_d = par_en ? ST_PARITY : ST_STOP;
            end
            ST_PARITY: begin
                if (sample_pt) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (sample_pt) state_d = is_brk ? ST_BRK_WAIT : ST_IDLE;
            end
            ST_BRK_WAIT: begin
                if (brk_over) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Tick counter, bit index, data shifter, parity bit, high-run counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            idx_q     <= '0;
            shreg_q   <= '0;
            par_bit_q <= 1'b0;
            hi_q      <= '0;
        end else begin
            if (state_q == ST_IDLE || state_q == ST_BRK_WAIT) begin
                cnt_q <= '0;
            end else if (tick) begin
                cnt_q <= sample_pt ? '0 : cnt_q + 1'b1;
            end

            if (state_q != ST_DATA) begin
                idx_q <= '0;
            end else if (sample_pt) begin
                idx_q <= idx_q + 1'b1;
            end

            if (state_q == ST_DATA && sample_pt) begin
                shreg_q <= {rxd_s, shreg_q[DATA_BITS-1:1]};
            end

            if (state_q == ST_START) begin
                par_bit_q <= 1'b0;
            end else if (state_q == ST_PARITY && sample_pt) begin
                par_bit_q <= rxd_s;
            end

            if (state_q != ST_BRK_WAIT) begin
                hi_q <= '0;
            end else if (tick) begin
                hi_q <= rxd_s ? hi_q + 1'b1 : '0;
            end
        end
    end

    // Output events, registered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt <= '0;
        end else begin
            evt.valid <= (state_q == ST_STOP) && sample_pt && !is_brk;
            evt.data  <= shreg_q;
            evt.ferr  <= (state_q == ST_STOP) && sample_pt && !is_brk && !rxd_s;
            evt.perr  <= (state_q == ST_STOP) && sample_pt && !is_brk && par_bad;
            evt.brk   <= ((state_q == ST_STOP) && sample_pt && is_brk) ||
                         ((state_q == ST_BRK_WAIT) && brk_over);
        end
    end
endmodule

// File: rtl/uart_brk_status.sv
module uart_brk_status
    import uart_brk_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  rx_evt_t              evt,
    input  logic                 clr,
    output logic [DATA_BITS-1:0] data,
    output logic                 valid,
    output logic                 ferr,
    output logic                 perr,
    output logic                 brk
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data  <= '0;
            valid <= 1'b0;
            ferr  <= 1'b0;
            perr  <= 1'b0;
            brk   <= 1'b0;
        end else begin
            valid <= evt.valid;
            if (evt.valid) data <= evt.data;
            if (clr) begin
                ferr <= 1'b0;
                perr <= 1'b0;
                brk  <= 1'b0;
            end else begin
                ferr <= ferr | evt.ferr;
                perr <= perr | evt.perr;
                brk  <= brk  | evt.brk;
            end
        end
    end
endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx
    import uart_brk_pkg::*;
#(
    parameter int DATA_BITS     = 8,
    parameter int OVS           = 16,
    parameter int SYNC_STAGES   = 2,
    parameter int BRK_END_TICKS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 os_tick,
    input  logic                 rxd,
    input  logic                 par_en,
    input  logic                 par_odd,
    input  logic                 rst_status,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 frame_err,
    output logic                 parity_err,
    output logic                 brk_flag
);
    logic    rxd_s;
    rx_evt_t evt;

    uart_brk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rxd_s)
    );

    uart_brk_fsm #(
        .DATA_BITS    (DATA_BITS),
        .OVS          (OVS),
        .BRK_END_TICKS(BRK_END_TICKS)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (os_tick),
        .rxd_s  (rxd_s),
        .par_en (par_en),
        .par_odd(par_odd),
        .evt    (evt)
    );

    uart_brk_status #(.DATA_BITS(DATA_BITS)) u_status (
        .clk  (clk),
        .rst_n(rst_n),
        .evt  (evt),
        .clr  (rst_status),
        .data (rx_data),
        .valid(rx_valid),
        .ferr (frame_err),
        .perr (parity_err),
        .brk  (brk_flag)
    );
endmodule

// File: rtl/uart_brk_rx_chk.sv
module uart_brk_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic par_en,
    input logic rst_status,
    input logic rx_valid,
    input logic frame_err,
    input logic parity_err,
    input logic brk_flag
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R2

    AST_PERR_WITH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(parity_err) |-> (rx_valid && par_en)); // R4

    AST_FERR_WITH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err) |-> rx_valid); // R5

    AST_BRK_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_flag) |-> !rx_valid); // R6

    AST_BRK_NO_FERR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_flag) |-> !$rose(frame_err)); // R6

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        rst_status |=> (!frame_err && !parity_err && !brk_flag)); // R8

    AST_FERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err && !rst_status) |=> frame_err); // R9

    AST_BRK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_flag && !rst_status) |=> brk_flag); // R9
endmodule

bind uart_brk_rx uart_brk_rx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .par_en    (par_en),
    .rst_status(rst_status),
    .rx_valid  (rx_valid),
    .frame_err (frame_err),
    .parity_err(parity_err),
    .brk_flag  (brk_flag)
);

// File: tb/uart_brk_rx_test.sv
module uart_brk_rx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rst_status = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       frame_err;
    logic       parity_err;
    logic       brk_flag;

    int n_checks = 0;
    int n_fail   = 0;
    int got_cnt  = 0;
    logic [7:0] got_data = 8'h00;
    bit done = 1'b0;

    uart_brk_rx uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .os_tick   (os_tick),
        .rxd       (rxd),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .rst_status(rst_status),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .frame_err (frame_err),
        .parity_err(parity_err),
        .brk_flag  (brk_flag)
    );

    always #5 clk = ~clk;

    initial begin
        forever begin
            repeat (3) @(posedge clk);
            os_tick <= 1'b1;
            @(posedge clk);
            os_tick <= 1'b0;
        end
    end

    always @(negedge clk) begin
        if (rx_valid) begin
            got_cnt  = got_cnt + 1;
            got_data = rx_data;
        end
    end

    function automatic logic par_bit_of(input logic [7:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n) @(negedge clk iff os_tick);
    endtask

    task automatic pulse_clear();
        @(negedge clk) rst_status = 1'b1;
        @(negedge clk) rst_status = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] d, input logic pe, input logic po,
                              input logic bad_par, input logic stop_v);
        par_en = pe;
        par_odd = po;
        wait_ticks(1);
        rxd = 1'b0;
        wait_ticks(16);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            wait_ticks(16);
        end
        if (pe) begin
            rxd = par_bit_of(d, po) ^ bad_par;
            wait_ticks(16);
        end
        rxd = stop_v;
        wait_ticks(16);
        rxd = 1'b1;
        wait_ticks(8);
    endtask

    task automatic frame_check(input logic [7:0] d, input logic pe, input logic po,
                               input logic bad_par, input logic stop_v, input string req);
        int  c0;
        bit  brk_exp;
        brk_exp = !stop_v && (d == 8'h00) && (!pe || !(par_bit_of(d, po) ^ bad_par));
        pulse_clear();
        c0 = got_cnt;
        send_frame(d, pe, po, bad_par, stop_v);
        if (brk_exp) begin
            check(got_cnt == c0, req, "break gave no byte", got_cnt - c0, 0);
            check(brk_flag == 1'b1, req, "brk_flag", brk_flag, 1);
            check(frame_err == 1'b0, req, "frame_err on break", frame_err, 0);
        end else begin
            check(got_cnt == c0 + 1, req, "one byte delivered", got_cnt - c0, 1);
            check(got_data == d, req, "data", got_data, d);
            check(frame_err == !stop_v, req, "frame_err", frame_err, !stop_v);
            check(parity_err == (pe && bad_par), req, "parity_err", parity_err, pe && bad_par);
            check(brk_flag == 1'b0, req, "brk_flag", brk_flag, 0);
        end
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int c0;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        // R1: reset state
        check(rx_valid == 0 && rx_data == 0, "R1", "outputs in reset", {rx_valid, rx_data}, 0);
        check({frame_err, parity_err, brk_flag} == 0, "R1", "flags in reset",
              {frame_err, parity_err, brk_flag}, 0);
        @(negedge clk) rst_n = 1'b1;
        wait_ticks(4);
        check(rx_valid == 0 && {frame_err, parity_err, brk_flag} == 0, "R1", "idle after reset",
              {rx_valid, frame_err, parity_err, brk_flag}, 0);

        // R2: plain frames, LSB first
        frame_check(8'hA5, 0, 0, 0, 1, "R2");
        frame_check(8'h01, 0, 0, 0, 1, "R2");
        frame_check(8'h80, 0, 0, 0, 1, "R2");
        // R4: parity even/odd good and bad
        frame_check(8'h37, 1, 0, 0, 1, "R4");
        frame_check(8'h37, 1, 1, 0, 1, "R4");
        frame_check(8'h5C, 1, 0, 1, 1, "R4");
        frame_check(8'h5C, 1, 1, 1, 1, "R4");
        // R5: zero stop bit, byte still delivered
        frame_check(8'h3C, 0, 0, 0, 0, "R5");
        frame_check(8'h00, 1, 0, 1, 0, "R5");

        // R9 sticky, then R8 clear
        pulse_clear();
        send_frame(8'h11, 0, 0, 0, 0);
        send_frame(8'h22, 0, 0, 0, 1);
        check(frame_err == 1'b1, "R9", "frame_err held after good frame", frame_err, 1);
        check(got_data == 8'h22, "R9", "second byte", got_data, 8'h22);
        pulse_clear();
        check(frame_err == 1'b0, "R8", "frame_err cleared", frame_err, 0);

        // R3: start glitch shorter than half a bit
        c0 = got_cnt;
        wait_ticks(1);
        rxd = 1'b0;
        wait_ticks(4);
        rxd = 1'b1;
        wait_ticks(40);
        check(got_cnt == c0, "R3", "glitch produced no byte", got_cnt - c0, 0);
        check({frame_err, parity_err, brk_flag} == 0, "R3", "glitch left flags",
              {frame_err, parity_err, brk_flag}, 0);

        // R6: break frame, no parity
        par_en = 1'b0;
        c0 = got_cnt;
        wait_ticks(1);
        rxd = 1'b0;
        wait_ticks(192);
        check(brk_flag == 1'b1, "R6", "brk_flag on break", brk_flag, 1);
        check(frame_err == 1'b0 && parity_err == 1'b0, "R6", "no error on break",
              {frame_err, parity_err}, 0);
        check(got_cnt == c0, "R6", "no byte on break", got_cnt - c0, 0);
        // R7: held low, then a one-tick high, must not end the break
        pulse_clear();
        wait_ticks(40);
        rxd = 1'b1;
        wait_ticks(1);
        rxd = 1'b0;
        wait_ticks(200);
        check(brk_flag == 1'b0, "R7", "single high tick ends no break", brk_flag, 0);
        check(got_cnt == c0, "R7", "no frame during break", got_cnt - c0, 0);
        rxd = 1'b1;
        wait_ticks(3);
        check(brk_flag == 1'b1, "R7", "end of break flag", brk_flag, 1);
        frame_check(8'h6B, 0, 0, 0, 1, "R7");

        // R6: break with parity enabled (parity bit zero)
        frame_check(8'h00, 1, 1, 1, 0, "R6");
        // R8: clear while flag set from end of break
        pulse_clear();
        check(brk_flag == 1'b0, "R8", "brk_flag cleared", brk_flag, 0);
        // R4: parity disabled never flags
        frame_check(8'hFF, 0, 1, 0, 1, "R4");

        // Random frames
        for (int k = 0; k < 40; k++) begin
            logic [7:0] d;
            logic pe, po, bp, sv;
            d  = 8'($urandom % 256);
            pe = 1'($urandom % 2);
            po = 1'($urandom % 2);
            bp = pe && ($urandom % 5 == 0);
            sv = ($urandom % 6 != 0);
            if ($urandom % 8 == 0) d = 8'h00;
            frame_check(d, pe, po, bp, sv, "R2");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule